// File: doc/BRIEF.md
# Flag-Setting Integer ALU

A purely combinational integer execution unit for a 64-bit datapath. It performs modular addition and subtraction, with and without an incoming carry, plus six bitwise operations. It also produces the next value of the four condition flags: negative, zero, carry and overflow. A width select picks 32-bit or 64-bit behaviour, and a set-flags enable picks whether a flag-capable operation writes the flags or passes the current ones through.

Operand preparation (shift or extend of the second operand), register access and instruction decode sit outside this block. The caller presents two ready operands, a 4-bit operation code, the width select and the set-flags enable, together with the current flags. The result and the next flags come back in the same cycle.

Top module: `flagAlu`

## Requirements
- R1: Operation codes: 0 add, 1 subtract, 2 add with carry, 3 subtract with carry, 4 AND, 5 bit-clear (opA & ~opB), 6 OR, 7 OR-NOT (opA | ~opB), 8 XOR, 9 XOR-NOT (opA ^ ~opB). Add gives opA+opB, subtract gives opA-opB, add with carry gives opA+opB+C and subtract with carry gives opA-opB-(1-C), all modulo 2^width, where C is curFlags[1].
- R2: With wide=0, only the low 32 bits of each operand are used and result[63:32] is zero. With wide=1 all 64 bits are used.
- R3: When flags are written, N (nextFlags[3]) equals result bit width-1: bit 31 when wide=0, bit 63 when wide=1.
- R4: When flags are written, Z (nextFlags[2]) is 1 exactly when the low width bits of the result are all zero.
- R5: For the four arithmetic codes, C (nextFlags[1]) is the carry out of bit width-1 of opA + opB' + cin. Here opB' is ~opB for the subtract forms, and cin is 0 for add, 1 for subtract and curFlags[1] for the carry forms. For subtract, C=1 therefore means no borrow.
- R6: For the arithmetic codes, V (nextFlags[0]) is 1 when the sign bits of opA and opB' agree and the result sign bit differs from them.
- R7: Each of the six bitwise codes returns its bitwise function, truncated to the width as in R2.
- R8: AND and bit-clear with setFlags=1 write N and Z from the result and force C and V to 0.
- R9: OR, OR-NOT, XOR and XOR-NOT never change the flags, even with setFlags=1: nextFlags equals curFlags.
- R10: With setFlags=0, nextFlags equals curFlags for every operation code.
- R11: Codes 10 to 15 are unused: the result is zero and nextFlags equals curFlags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 64 | First operand |
| opB | input | 64 | Second operand (already shifted or extended) |
| opSel | input | 4 | Operation code, see R1 and R11 |
| wide | input | 1 | 1 selects 64-bit mode, 0 selects 32-bit mode |
| setFlags | input | 1 | 1 lets a flag-capable operation write the flags |
| curFlags | input | 4 | Current flags {N,Z,C,V}; bit 1 is the carry consumed by codes 2 and 3 |
| result | output | 64 | Operation result |
| nextFlags | output | 4 | Next flags {N,Z,C,V} |

## Verification
The embedded assertions assume that every input is at a known level. Each check is gated so that it stays quiet while any input is still unknown. The stimulus drives all inputs from the first instant, so the gate opens before the first comparison. The random vectors cover all sixteen codes, both widths, both set-flags settings and random carry values. This reaches the unused codes, the operations that never write flags and the borrow-driven carry forms with known operands. Directed vectors pin down the edges of the sign and carry arithmetic: a carry out of bit 31, signed overflow at bit 63, an exact-zero subtract and a borrow. They also show that upper operand bits have no effect in 32-bit mode.

// File: rtl/aluPkg.sv
package aluPkg;
  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_SUB = 4'd1, OP_ADC = 4'd2, OP_SBC = 4'd3,
    OP_AND = 4'd4, OP_BIC = 4'd5, OP_ORR = 4'd6, OP_ORN = 4'd7,
    OP_EOR = 4'd8, OP_EON = 4'd9
  } aluOp_e;

  typedef enum logic [1:0] { CIN_ZERO = 2'd0, CIN_ONE = 2'd1, CIN_FLAG = 2'd2 } cinSel_e;
  typedef enum logic [1:0] { LF_AND = 2'd0, LF_OR = 2'd1, LF_XOR = 2'd2 } logicFn_e;

  // Strobes passed from the control decoder to the datapath
  typedef struct packed {
    logic     valid;       // known operation code
    logic     isArith;     // adder result, else bitwise result
    logic     invB;        // use ~opB
    cinSel_e  cinSel;
    logicFn_e logicFn;
    logic     flagCapable; // may write flags when setFlags is high
  } aluStrobe_t;
endpackage

// File: rtl/aluCtrl.sv
module aluCtrl
  import aluPkg::*;
#(
  parameter int OP_W = 4
) (
  input  logic [OP_W-1:0] opSel,
  output aluStrobe_t      strobe
);
  always_comb begin
    strobe = '{valid: 1'b1, isArith: 1'b0, invB: 1'b0, cinSel: CIN_ZERO,
               logicFn: LF_AND, flagCapable: 1'b0};
    case (opSel)
      OP_ADD: begin strobe.isArith = 1'b1; strobe.flagCapable = 1'b1; end
      OP_SUB: begin strobe.isArith = 1'b1; strobe.invB = 1'b1; strobe.cinSel = CIN_ONE;
                    strobe.flagCapable = 1'b1; end
      OP_ADC: begin strobe.isArith = 1'b1; strobe.cinSel = CIN_FLAG; strobe.flagCapable = 1'b1; end
      OP_SBC: begin strobe.isArith = 1'b1; strobe.invB = 1'b1; strobe.cinSel = CIN_FLAG;
                    strobe.flagCapable = 1'b1; end
      OP_AND: strobe.flagCapable = 1'b1;
      OP_BIC: begin strobe.invB = 1'b1; strobe.flagCapable = 1'b1; end
      OP_ORR: strobe.logicFn = LF_OR;
      OP_ORN: begin strobe.logicFn = LF_OR; strobe.invB = 1'b1; end
      OP_EOR: strobe.logicFn = LF_XOR;
      OP_EON: begin strobe.logicFn = LF_XOR; strobe.invB = 1'b1; end
      default: strobe.valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import aluPkg::*;
#(
  parameter int DATA_W = 64
) (
  input  aluStrobe_t        strobe,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              wide,
  input  logic              setFlags,
  input  logic [3:0]        curFlags,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        nextFlags
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] bEff, logicRes, rawRes;
  logic [DATA_W:0]   sumFull;
  logic              cin, signBit, zeroBit, cOut, vOut, aSign, bSign, writeFlags;

  always_comb begin
    bEff = strobe.invB ? ~opB : opB;
    case (strobe.cinSel)
      CIN_ONE:  cin = 1'b1;
      CIN_FLAG: cin = curFlags[1];
      default:  cin = 1'b0;
    endcase
    sumFull = {1'b0, opA} + {1'b0, bEff} + {{DATA_W{1'b0}}, cin};
    case (strobe.logicFn)
      LF_OR:   logicRes = opA | bEff;
      LF_XOR:  logicRes = opA ^ bEff;
      default: logicRes = opA & bEff;
    endcase
    rawRes = !strobe.valid ? '0 : (strobe.isArith ? sumFull[DATA_W-1:0] : logicRes);
    result = wide ? rawRes : {{HALF_W{1'b0}}, rawRes[HALF_W-1:0]};
    signBit = wide ? result[DATA_W-1] : result[HALF_W-1];
    zeroBit = (result == '0);
    // carry into bit HALF_W is the 32-bit carry out
    cOut = wide ? sumFull[DATA_W] : (sumFull[HALF_W] ^ opA[HALF_W] ^ bEff[HALF_W]);
    aSign = wide ? opA[DATA_W-1] : opA[HALF_W-1];
    bSign = wide ? bEff[DATA_W-1] : bEff[HALF_W-1];
    vOut = (aSign == bSign) && (signBit != aSign);
    writeFlags = setFlags && strobe.flagCapable;
    nextFlags = writeFlags
              ? {signBit, zeroBit, strobe.isArith & cOut, strobe.isArith & vOut}
              : curFlags;
  end

  always_comb begin
    if (!$isunknown({opA, opB, wide, setFlags, curFlags, strobe})) begin
      if (!wide)
        AST_UPPER_ZERO: assert (result[DATA_W-1:HALF_W] == '0); // R2
      if (writeFlags)
        AST_NEG_BIT: assert (nextFlags[3] == (wide ? result[DATA_W-1] : result[HALF_W-1])); // R3
      if (writeFlags)
        AST_ZERO_BIT: assert (nextFlags[2] == (result == '0)); // R4
      if (!setFlags)
        AST_FLAGS_HELD: assert (nextFlags == curFlags); // R10
    end
  end
endmodule

// File: rtl/flagAlu.sv
module flagAlu
  import aluPkg::*;
#(
  parameter int DATA_W = 64,
  parameter int OP_W   = 4
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [OP_W-1:0]   opSel,
  input  logic              wide,
  input  logic              setFlags,
  input  logic [3:0]        curFlags,
  output logic [DATA_W-1:0] result,
  output logic [3:0]        nextFlags
);
  aluStrobe_t strobe;

  aluCtrl #(.OP_W(OP_W)) uCtrl (.opSel(opSel), .strobe(strobe));

  aluDatapath #(.DATA_W(DATA_W)) uPath (
    .strobe(strobe), .opA(opA), .opB(opB), .wide(wide), .setFlags(setFlags),
    .curFlags(curFlags), .result(result), .nextFlags(nextFlags)
  );

  always_comb begin
    if (!$isunknown({opA, opB, opSel, wide, setFlags, curFlags})) begin
      if (setFlags && (opSel == OP_AND || opSel == OP_BIC))
        AST_LOGIC_CV_CLEAR: assert (nextFlags[1:0] == 2'b00); // R8
      if (opSel >= OP_ORR)
        AST_NO_FLAG_WRITE: assert (nextFlags == curFlags); // R9
      if (opSel > OP_EON)
        AST_UNUSED_ZERO: assert (result == '0); // R11
    end
  end
endmodule

// File: tb/test_flagAlu.sv
module test_flagAlu;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [63:0] opA = '0, opB = '0;
  logic [3:0]  opSel = '0, curFlags = '0;
  logic        wide = 1'b0, setFlags = 1'b0;
  logic [63:0] result;
  logic [3:0]  nextFlags;
  int nChecks = 0, nFails = 0;

  always #5 clk = ~clk;

  flagAlu i_flagAlu (.opA(opA), .opB(opB), .opSel(opSel), .wide(wide),
    .setFlags(setFlags), .curFlags(curFlags), .result(result), .nextFlags(nextFlags));

  // reference: {flags, result}
  function automatic logic [67:0] refAlu(logic [63:0] a, logic [63:0] b, logic [3:0] op,
                                         logic w, logic sf, logic [3:0] cf);
    logic [63:0] am, bm, r;
    logic [64:0] s;
    logic [3:0] f;
    logic n, c, v, as, bs;
    am = w ? a : {32'b0, a[31:0]};
    bm = w ? b : {32'b0, b[31:0]};
    f = cf; r = '0; c = 0; v = 0;
    if (op <= 3) begin
      if (op == 1 || op == 3) bm = w ? ~bm : {32'b0, ~bm[31:0]};
      s = {1'b0, am} + {1'b0, bm} + ((op == 0) ? 65'd0 : (op == 1) ? 65'd1 : {64'd0, cf[1]});
      r = w ? s[63:0] : {32'b0, s[31:0]};
      c = w ? s[64] : s[32];
      as = w ? am[63] : am[31];
      bs = w ? bm[63] : bm[31];
      n = w ? r[63] : r[31];
      v = (as == bs) && (n != as);
      if (sf) f = {n, r == 0, c, v};
    end else if (op <= 9) begin
      case (op)
        4: r = am & bm;
        5: r = am & ~bm;
        6: r = am | bm;
        7: r = am | ~bm;
        8: r = am ^ bm;
        default: r = am ^ ~bm;
      endcase
      if (!w) r[63:32] = '0;
      n = w ? r[63] : r[31];
      if (sf && op <= 5) f = {n, r == 0, 2'b00};
    end
    return {f, r};
  endfunction

  task automatic drive(logic [63:0] a, logic [63:0] b, logic [3:0] op, logic w,
                       logic sf, logic [3:0] cf);
    @(posedge clk);
    opA = a; opB = b; opSel = op; wide = w; setFlags = sf; curFlags = cf;
    @(negedge clk);
  endtask

  task automatic check(string tag, logic [63:0] expR, logic [3:0] expF);
    nChecks++;
    if (result !== expR) begin
      nFails++;
      $display("FAIL %s result actual=%h expected=%h", tag, result, expR);
    end
    if (nextFlags !== expF) begin
      nFails++;
      $display("FAIL %s flags actual=%b expected=%b", tag, nextFlags, expF);
    end
  endtask

  initial begin
    #200000;
    nFails++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [67:0] e;
    void'($urandom(32'h1234abcd));
    @(negedge clk);
    check("R10 reset state", 64'd0, 4'b0000);
    rstN = 1'b1;

    // R5 R4: 32-bit wrap with carry out
    drive(64'hFFFF_FFFF, 64'd1, 4'd0, 0, 1, 4'b0000);
    check("R5 32b carry out", 64'd0, 4'b0110);
    // R6 R3: 64-bit signed overflow
    drive(64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 4'd0, 1, 1, 4'b0000);
    check("R6 64b overflow", 64'h8000_0000_0000_0000, 4'b1001);
    // R4 R5: exact-zero subtract, no borrow
    drive(64'd5, 64'd5, 4'd1, 1, 1, 4'b0000);
    check("R4 sub zero", 64'd0, 4'b0110);
    // R5 R3: borrow
    drive(64'd0, 64'd1, 4'd1, 1, 1, 4'b0000);
    check("R5 borrow", 64'hFFFF_FFFF_FFFF_FFFF, 4'b1000);
    // R1: subtract with carry, C=0 takes one more
    drive(64'd5, 64'd3, 4'd3, 1, 0, 4'b0000);
    check("R1 sbc c0", 64'd1, 4'b0000);
    // R1: add with carry, C=1
    drive(64'd5, 64'd3, 4'd2, 1, 1, 4'b0010);
    check("R1 adc c1", 64'd9, 4'b0000);
    // R2: upper operand bits ignored in 32-bit mode
    drive(64'hDEAD_BEEF_0000_0002, 64'h1234_5678_0000_0003, 4'd0, 0, 1, 4'b0000);
    check("R2 upper ignored", 64'd5, 4'b0000);
    // R8: AND with flags clears C,V
    drive(64'hF0, 64'h0F, 4'd4, 1, 1, 4'b0011);
    check("R8 and zero", 64'd0, 4'b0100);
    drive(64'hFFFF_FFFF, 64'h8000_0001, 4'd5, 0, 1, 4'b0011);
    check("R8 bic 32b", 64'h7FFF_FFFE, 4'b0000);
    // R9: xor never writes flags
    drive(64'hAA, 64'hAA, 4'd8, 1, 1, 4'b1011);
    check("R9 xor held", 64'd0, 4'b1011);
    // R7: or-not / xor-not in 32-bit mode
    drive(64'h0, 64'hFFFF_0000, 4'd7, 0, 0, 4'b0000);
    check("R7 orn 32b", 64'h0000_FFFF, 4'b0000);
    drive(64'h1, 64'h0, 4'd9, 1, 0, 4'b0101);
    check("R7 eon", 64'hFFFF_FFFF_FFFF_FFFE, 4'b0101);
    // R11: unused code
    drive(64'h55, 64'h66, 4'd12, 1, 1, 4'b1010);
    check("R11 unused", 64'd0, 4'b1010);
    // R10: add without flag write
    drive(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 4'd0, 1, 0, 4'b1001);
    check("R10 held", 64'd0, 4'b1001);

    for (int i = 0; i < 3000; i++) begin
      logic [63:0] a, b;
      logic [3:0] op, cf;
      logic w, sf;
      a = {$urandom, $urandom}; b = {$urandom, $urandom};
      if (i % 7 == 0) b = a;
      if (i % 11 == 0) a = 64'h8000_0000_7FFF_FFFF;
      op = 4'($urandom); cf = 4'($urandom);
      w = 1'($urandom); sf = 1'($urandom);
      drive(a, b, op, w, sf, cf);
      e = refAlu(a, b, op, w, sf, cf);
      check(op <= 3 ? "R1 R5 R6 random arith" : op <= 9 ? "R7 random logic" : "R11 random unused",
            e[63:0], e[67:64]);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule